// File: doc/BRIEF.md
# Multiprocessor Interrupt Mask Controller

This block collects the interrupt lines of on-board devices and expansion-bus slots. It combines them with a software interrupt register and a timer line for each of up to four processors. For each processor it produces a 4-bit processor interrupt level, which is the highest level that is currently active for that processor.

Device lines pass through a global mask before they count. Bit 31 of the mask is a master bit that blocks every device line. The mask cannot be written directly. Software changes it through two aliases: one that sets the bits written as 1 and one that clears them. A target register selects the single processor that receives unmasked device interrupts. Soft and hard bits in each processor's own register always reach that processor.

A simple synchronous register port gives access to the registers. Writes take effect at the clock edge where `wr_en` is high. A read returns its data on `rdata` one cycle after `rd_en`. Word addresses on `addr`:

- 0 reads the raw device lines.
- 1 reads the mask.
- 2 is mask-clear.
- 3 is mask-set.
- 4 is the target.
- For processor c, the block sits at base 8+4c: +0 reads its pending bits, +1 is its clear register and +2 is its set register.

Top module: `mp_irq_ctrl`

## Requirements
- R1: After reset the mask reads 0xFFFF_FFFF, the target reads 0, every processor's pending register reads 0 and every `cpu_level` field is 0.
- R2: A write to address 3 sets the mask bits whose `wdata` bit is 1. A write to address 2 clears the mask bits whose `wdata` bit is 1. Mask bits written as 0 keep their value, and no other access changes the mask.
- R3: While mask bit 31 is 1, no device line raises any processor's level.
- R4: An unmasked, active device line at bit b requests a fixed level:
  - bit 7 requests level 2, bit 8 level 3, bit 9 level 5 and bit 10 level 7.
  - bits 11 and 30 request level 9, and bit 19 requests level 10.
  - bits 12 and 22 request level 11, and bits 14 and 15 request level 12.
  - bit 16 requests level 6, bit 17 level 13, bit 18 level 4 and bit 20 level 8.
  - Any other device bit requests no level.
- R5: A processor's level is the highest of all the levels requested for it, or 0 when none is requested.
- R6: Device requests reach only the processor whose index equals the target register, which is written at address 4.
- R7: In a processor's pending register, bit x and bit 16+x each request level x, for x from 1 to 15. Writing 1s to its set address raises those bits and writing 1s to its clear address drops them. A clear write of 0xFFFE_8000 drops bits 31 to 17 and bit 15 and keeps bits 16 and 14 to 0.
- R8: A high `cpu_timer[c]` requests level 14 for processor c only, whatever the mask and target hold. Bit 14 of that processor's pending read is 1 while the line is high.
- R9: A read of address 0 returns `dev_irq` as sampled at the read, and a read of address 1 returns the current mask.
- R10: `cpu_level` is registered. It reflects inputs and register state from the previous clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W (5) | Register word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid the cycle after `rd_en` |
| dev_irq | input | 32 | Raw device interrupt lines, active high |
| cpu_timer | input | NUM_CPU (4) | Level-14 timer line of each processor |
| cpu_level | output | 4*NUM_CPU (16) | Interrupt level of each processor, 4 bits per processor, processor 0 in the low bits |

## Verification
The assertions check the following on every cycle:
- Set and clear writes change exactly the mask bits they name.
- The mask holds whenever neither alias is written.
- The master bit silences a processor with no soft bits and no timer request.
- A processor that is not the target and has no soft bits and no timer request stays at level 0.
- A timer line raises its processor to at least level 14.

Only the bench's scenarios can show the remaining behaviour:
- The exact level assigned to each device bit.
- The choice of the highest level among simultaneous sources.
- Device interrupts following a change of target.
- The clear pattern that spares the low bits.
- The values returned by reads.

// File: rtl/mp_irq_pkg.sv
package mp_irq_pkg;

    localparam int REG_W      = 32;
    localparam int LVL_W      = 4;
    localparam int NUM_LVL    = 16;
    localparam int MASTER_BIT = 31;
    localparam int TIMER_LVL  = 14;

    // global register word offsets
    localparam int A_DEV_PEND = 0;
    localparam int A_MASK     = 1;
    localparam int A_MASK_CLR = 2;
    localparam int A_MASK_SET = 3;
    localparam int A_TARGET   = 4;

    // per-processor region
    localparam int CPU_BASE   = 8;
    localparam int CPU_STRIDE = 4;
    localparam int O_PEND     = 0;
    localparam int O_CLR      = 1;
    localparam int O_SET      = 2;

    // Fixed level assigned to each device bit; 0 means no request.
    function automatic logic [LVL_W-1:0] dev_bit_level(input int unsigned b);
        logic [LVL_W-1:0] l;
        case (b)
            7:       l = 4'd2;
            8:       l = 4'd3;
            9:       l = 4'd5;
            10:      l = 4'd7;
            11:      l = 4'd9;
            12:      l = 4'd11;
            14:      l = 4'd12;
            15:      l = 4'd12;
            16:      l = 4'd6;
            17:      l = 4'd13;
            18:      l = 4'd4;
            19:      l = 4'd10;
            20:      l = 4'd8;
            22:      l = 4'd11;
            30:      l = 4'd9;
            default: l = 4'd0;
        endcase
        return l;
    endfunction

endpackage

// File: rtl/mp_irq_dev_map.sv
module mp_irq_dev_map
    import mp_irq_pkg::*;
#(
    parameter int N_DEV = REG_W,
    parameter int N_LVL = NUM_LVL
) (
    input  logic [N_DEV-1:0] dev_act,
    output logic [N_LVL-1:0] lvl_req
);

    always_comb begin
        lvl_req = '0;
        for (int b = 0; b < N_DEV; b++) begin
            if (dev_act[b] && (dev_bit_level(b) != '0)) begin
                lvl_req[dev_bit_level(b)] = 1'b1;
            end
        end
    end

endmodule

// File: rtl/mp_irq_prio_enc.sv
module mp_irq_prio_enc #(
    parameter int N_LVL = 16,
    localparam int L_W  = $clog2(N_LVL)
) (
    input  logic [N_LVL-1:0] req,
    output logic [L_W-1:0]   lvl
);

    // level 0 never counts as a request; the highest set index wins
    always_comb begin
        lvl = '0;
        for (int i = 1; i < N_LVL; i++) begin
            if (req[i]) begin
                lvl = L_W'(i);
            end
        end
    end

endmodule

// File: rtl/mp_irq_soft_bank.sv
module mp_irq_soft_bank
    import mp_irq_pkg::*;
#(
    parameter int W     = REG_W,
    parameter int N_LVL = NUM_LVL,
    localparam int HALF = W / 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_we,
    input  logic             clr_we,
    input  logic [W-1:0]     wdata,
    output logic [W-1:0]     bits,
    output logic [N_LVL-1:0] lvl_req
);

    typedef struct packed {
        logic [W-1:0] bits;
    } bank_t;

    bank_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (set_we) begin
            st_d.bits = st_d.bits | wdata;
        end
        if (clr_we) begin
            st_d.bits = st_d.bits & ~wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bits = st_q.bits;

    // hard bit x and soft bit HALF+x both request level x
    generate
        for (genvar x = 0; x < N_LVL; x++) begin : g_req
            if (x == 0 || x >= HALF) begin : g_none
                assign lvl_req[x] = 1'b0;
            end else begin : g_lvl
                assign lvl_req[x] = st_q.bits[x] | st_q.bits[HALF + x];
            end
        end
    endgenerate

endmodule

// File: rtl/mp_irq_ctrl.sv
module mp_irq_ctrl
    import mp_irq_pkg::*;
#(
    parameter int NUM_CPU = 4,
    parameter int ADDR_W  = 5,
    localparam int TGT_W  = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic                     rd_en,
    input  logic [ADDR_W-1:0]        addr,
    input  logic [REG_W-1:0]         wdata,
    output logic [REG_W-1:0]         rdata,
    input  logic [REG_W-1:0]         dev_irq,
    input  logic [NUM_CPU-1:0]       cpu_timer,
    output logic [LVL_W*NUM_CPU-1:0] cpu_level
);

    typedef struct packed {
        logic [REG_W-1:0]                mask;
        logic [TGT_W-1:0]                target;
        logic [REG_W-1:0]                rdata;
        logic [NUM_CPU-1:0][LVL_W-1:0]   level;
    } glob_t;

    glob_t st_d, st_q;

    logic [REG_W-1:0]             mask_cur;
    logic [TGT_W-1:0]             target_cur;
    logic [REG_W-1:0]             dev_act;
    logic [NUM_LVL-1:0]           dev_req;
    logic [NUM_CPU-1:0]           bank_set_we;
    logic [NUM_CPU-1:0]           bank_clr_we;
    logic [NUM_CPU*REG_W-1:0]     cpu_bits;
    logic [NUM_CPU-1:0][REG_W-1:0] cpu_pend_rd;
    logic [NUM_CPU-1:0][LVL_W-1:0] cpu_lvl_now;

    assign mask_cur   = st_q.mask;
    assign target_cur = st_q.target;

    // device lines pass only when their mask bit and the master bit are clear
    assign dev_act = dev_irq & ~mask_cur & {REG_W{~mask_cur[MASTER_BIT]}};

    mp_irq_dev_map #(
        .N_DEV (REG_W),
        .N_LVL (NUM_LVL)
    ) i_dev_map (
        .dev_act (dev_act),
        .lvl_req (dev_req)
    );

    generate
        for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
            localparam int ABASE = CPU_BASE + c * CPU_STRIDE;

            logic [NUM_LVL-1:0] soft_req;
            logic [NUM_LVL-1:0] all_req;
            logic [NUM_LVL-1:0] tmr_req;

            assign bank_set_we[c] = wr_en && (addr == ADDR_W'(ABASE + O_SET));
            assign bank_clr_we[c] = wr_en && (addr == ADDR_W'(ABASE + O_CLR));

            mp_irq_soft_bank #(
                .W     (REG_W),
                .N_LVL (NUM_LVL)
            ) i_bank (
                .clk     (clk),
                .rst_n   (rst_n),
                .set_we  (bank_set_we[c]),
                .clr_we  (bank_clr_we[c]),
                .wdata   (wdata),
                .bits    (cpu_bits[c*REG_W +: REG_W]),
                .lvl_req (soft_req)
            );

            assign tmr_req = cpu_timer[c] ? (NUM_LVL'(1) << TIMER_LVL) : '0;
            assign all_req = soft_req | tmr_req
                           | ((target_cur == TGT_W'(c)) ? dev_req : '0);

            assign cpu_pend_rd[c] = cpu_bits[c*REG_W +: REG_W]
                                  | (cpu_timer[c] ? (REG_W'(1) << TIMER_LVL) : '0);

            mp_irq_prio_enc #(
                .N_LVL (NUM_LVL)
            ) i_prio (
                .req (all_req),
                .lvl (cpu_lvl_now[c])
            );
        end
    endgenerate

    always_comb begin
        logic [REG_W-1:0] rd_val;

        st_d = st_q;

        // mask write aliases and target
        if (wr_en && (addr == ADDR_W'(A_MASK_SET))) begin
            st_d.mask = st_q.mask | wdata;
        end
        if (wr_en && (addr == ADDR_W'(A_MASK_CLR))) begin
            st_d.mask = st_q.mask & ~wdata;
        end
        if (wr_en && (addr == ADDR_W'(A_TARGET))) begin
            st_d.target = wdata[TGT_W-1:0];
        end

        // read mux
        rd_val = '0;
        if (addr == ADDR_W'(A_DEV_PEND)) rd_val = dev_irq;
        if (addr == ADDR_W'(A_MASK))     rd_val = st_q.mask;
        if (addr == ADDR_W'(A_TARGET))   rd_val = REG_W'(st_q.target);
        for (int c = 0; c < NUM_CPU; c++) begin
            if (addr == ADDR_W'(CPU_BASE + c * CPU_STRIDE + O_PEND)) begin
                rd_val = cpu_pend_rd[c];
            end
        end
        if (rd_en) begin
            st_d.rdata = rd_val;
        end

        st_d.level = cpu_lvl_now;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.mask   <= '1;
            st_q.target <= '0;
            st_q.rdata  <= '0;
            st_q.level  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rdata     = st_q.rdata;
    assign cpu_level = st_q.level;

endmodule

// File: rtl/mp_irq_ctrl_chk.sv
module mp_irq_ctrl_chk
    import mp_irq_pkg::*;
#(
    parameter int NUM_CPU = 4,
    parameter int ADDR_W  = 5,
    localparam int TGT_W  = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     wr_en,
    input logic [ADDR_W-1:0]        addr,
    input logic [REG_W-1:0]         wdata,
    input logic [NUM_CPU-1:0]       cpu_timer,
    input logic [LVL_W*NUM_CPU-1:0] cpu_level,
    input logic [REG_W-1:0]         mask_cur,
    input logic [TGT_W-1:0]         target_cur,
    input logic [NUM_CPU*REG_W-1:0] cpu_bits
);

    logic set_wr, clr_wr;
    assign set_wr = wr_en && (addr == ADDR_W'(A_MASK_SET));
    assign clr_wr = wr_en && (addr == ADDR_W'(A_MASK_CLR));

    a_r2_set_alias: assert property (@(posedge clk) disable iff (!rst_n)
        set_wr |=> ((mask_cur & $past(wdata)) == $past(wdata)));

    a_r2_clr_alias: assert property (@(posedge clk) disable iff (!rst_n)
        clr_wr |=> ((mask_cur & $past(wdata)) == '0));

    a_r2_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(set_wr || clr_wr) |=> $stable(mask_cur));

    generate
        for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu_chk
            a_r3_master_silences: assert property (@(posedge clk) disable iff (!rst_n)
                (mask_cur[MASTER_BIT] && (cpu_bits[c*REG_W +: REG_W] == '0) && !cpu_timer[c])
                |=> (cpu_level[c*LVL_W +: LVL_W] == '0));

            a_r6_non_target_quiet: assert property (@(posedge clk) disable iff (!rst_n)
                ((target_cur != TGT_W'(c)) && (cpu_bits[c*REG_W +: REG_W] == '0) && !cpu_timer[c])
                |=> (cpu_level[c*LVL_W +: LVL_W] == '0));

            a_r8_timer_level: assert property (@(posedge clk) disable iff (!rst_n)
                cpu_timer[c] |=> (cpu_level[c*LVL_W +: LVL_W] >= LVL_W'(TIMER_LVL)));
        end
    endgenerate

endmodule

bind mp_irq_ctrl mp_irq_ctrl_chk #(
    .NUM_CPU (NUM_CPU),
    .ADDR_W  (ADDR_W)
) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .addr       (addr),
    .wdata      (wdata),
    .cpu_timer  (cpu_timer),
    .cpu_level  (cpu_level),
    .mask_cur   (mask_cur),
    .target_cur (target_cur),
    .cpu_bits   (cpu_bits)
);

// File: tb/test_mp_irq_ctrl.sv
module test_mp_irq_ctrl;

    localparam int NCPU = 4;
    localparam int AW   = 5;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            wr_en = 1'b0;
    logic            rd_en = 1'b0;
    logic [AW-1:0]   addr = '0;
    logic [31:0]     wdata = '0;
    logic [31:0]     rdata;
    logic [31:0]     dev_irq = '0;
    logic [NCPU-1:0] cpu_timer = '0;
    logic [4*NCPU-1:0] cpu_level;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #4 clk = ~clk;

    mp_irq_ctrl #(.NUM_CPU(NCPU), .ADDR_W(AW)) i_mp_irq_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .rd_en     (rd_en),
        .addr      (addr),
        .wdata     (wdata),
        .rdata     (rdata),
        .dev_irq   (dev_irq),
        .cpu_timer (cpu_timer),
        .cpu_level (cpu_level)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = AW'(a); wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        @(negedge clk);
        rd_en = 1'b1; addr = AW'(a);
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata;
    endtask

    // one more edge so that the registered level has caught up
    task automatic settle();
        @(negedge clk);
    endtask

    function automatic logic [3:0] lvl_of(input int c);
        return cpu_level[c*4 +: 4];
    endfunction

    task automatic t_reset();
        logic [31:0] d;
        rd(1, d); check("R1 mask after reset", d, 32'hFFFF_FFFF);
        rd(4, d); check("R1 target after reset", d, 0);
        for (int c = 0; c < NCPU; c++) begin
            rd(8 + 4*c, d); check("R1 cpu pending after reset", d, 0);
            check("R1 level after reset", 32'(lvl_of(c)), 0);
        end
    endtask

    task automatic t_mask_alias();
        logic [31:0] d;
        wr(2, 32'h0000_FF00);
        rd(1, d); check("R2 clear alias", d, 32'hFFFF_00FF);
        wr(3, 32'h0000_0100);
        rd(1, d); check("R2 set alias", d, 32'hFFFF_01FF);
        wr(2, 32'h0);
        wr(3, 32'h0);
        rd(1, d); check("R2 zero writes keep mask", d, 32'hFFFF_01FF);
        wr(4, 0);
        rd(1, d); check("R2 other write keeps mask", d, 32'hFFFF_01FF);
    endtask

    task automatic t_master();
        wr(2, 32'h7FFF_FFFF);
        @(negedge clk); dev_irq = 32'h1 << 18;
        settle(); settle();
        check("R3 master bit blocks device", 32'(lvl_of(0)), 0);
        wr(2, 32'h8000_0000);
        settle();
        check("R3 master cleared passes device", 32'(lvl_of(0)), 4);
        @(negedge clk); dev_irq = '0;
        settle();
    endtask

    task automatic t_table();
        int bits[15] = '{7, 8, 18, 9, 16, 10, 20, 11, 30, 19, 12, 22, 15, 14, 17};
        int lvls[15] = '{2, 3, 4, 5, 6, 7, 8, 9, 9, 10, 11, 11, 12, 12, 13};
        for (int i = 0; i < 15; i++) begin
            @(negedge clk); dev_irq = 32'h1 << bits[i];
            settle();
            check($sformatf("R4 bit %0d level", bits[i]), 32'(lvl_of(0)), 32'(lvls[i]));
        end
        @(negedge clk); dev_irq = 32'h1 << 21;
        settle();
        check("R4 unmapped bit 21", 32'(lvl_of(0)), 0);
        @(negedge clk); dev_irq = '0;
        settle();
    endtask

    task automatic t_latency();
        @(negedge clk); dev_irq = 32'h1 << 20;
        #1;
        check("R10 level not yet updated", 32'(lvl_of(0)), 0);
        settle();
        check("R10 level after one edge", 32'(lvl_of(0)), 8);
        @(negedge clk); dev_irq = '0;
        settle();
    endtask

    task automatic t_prio();
        @(negedge clk); dev_irq = (32'h1 << 18) | (32'h1 << 20) | (32'h1 << 17);
        settle();
        check("R5 highest of 4,8,13", 32'(lvl_of(0)), 13);
        wr(3, 32'h1 << 17);
        settle();
        check("R5 masked source drops out", 32'(lvl_of(0)), 8);
        wr(2, 32'h1 << 17);
        @(negedge clk); dev_irq = (32'h1 << 18) | (32'h1 << 7);
        settle();
        check("R5 highest of 2,4", 32'(lvl_of(0)), 4);
        @(negedge clk); dev_irq = '0;
        settle();
    endtask

    task automatic t_target();
        @(negedge clk); dev_irq = 32'h1 << 19;
        wr(4, 2);
        settle();
        check("R6 target cpu2 gets level", 32'(lvl_of(2)), 10);
        check("R6 cpu0 no longer gets device", 32'(lvl_of(0)), 0);
        wr(4, 0);
        settle();
        check("R6 back to cpu0", 32'(lvl_of(0)), 10);
        check("R6 cpu2 released", 32'(lvl_of(2)), 0);
        @(negedge clk); dev_irq = '0;
        settle();
    endtask

    task automatic t_soft();
        logic [31:0] d;
        wr(8 + 4*1 + 2, 32'h1 << 21);
        settle();
        check("R7 soft bit 5 on cpu1", 32'(lvl_of(1)), 5);
        check("R7 cpu0 unaffected", 32'(lvl_of(0)), 0);
        wr(8 + 4*1 + 2, (32'h1 << 9) | (32'h1 << 3));
        settle();
        check("R7 hard bit 9 on cpu1", 32'(lvl_of(1)), 9);
        wr(8 + 4*1 + 1, 32'h1 << 9);
        settle();
        check("R7 clear hard bit 9", 32'(lvl_of(1)), 5);
        wr(8 + 4*1 + 1, 32'hFFFE_8000);
        settle();
        check("R7 init clear keeps low bits", 32'(lvl_of(1)), 3);
        rd(8 + 4*1, d); check("R7 cpu1 pending after clear", d, 32'h8);
        wr(8 + 4*1 + 1, 32'h8);
        settle();
        check("R7 cpu1 idle", 32'(lvl_of(1)), 0);
    endtask

    task automatic t_timer();
        logic [31:0] d;
        @(negedge clk); cpu_timer = 4'b1000;
        settle();
        check("R8 timer cpu3 level 14", 32'(lvl_of(3)), 14);
        check("R8 timer not on cpu0", 32'(lvl_of(0)), 0);
        rd(8 + 4*3, d); check("R8 pending shows timer", d, 32'h1 << 14);
        wr(4, 3);
        @(negedge clk); dev_irq = 32'h1 << 19;
        settle();
        check("R8 timer beats device level 10", 32'(lvl_of(3)), 14);
        @(negedge clk); cpu_timer = '0;
        settle();
        check("R8 device after timer drops", 32'(lvl_of(3)), 10);
        @(negedge clk); dev_irq = '0;
        wr(4, 0);
        settle();
    endtask

    task automatic t_reads();
        logic [31:0] d;
        @(negedge clk); dev_irq = 32'h1234_5678;
        rd(0, d); check("R9 raw device lines", d, 32'h1234_5678);
        wr(3, 32'h00F0_0000);
        rd(1, d); check("R9 mask readback", d, 32'h00F0_0000);
        @(negedge clk); dev_irq = '0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        settle();
        t_reset();
        t_mask_alias();
        t_master();
        t_table();
        t_latency();
        t_prio();
        t_target();
        t_soft();
        t_timer();
        t_reads();
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule